// File: doc/BRIEF.md
# PDM Microphone Channel Sampler

This block takes up to eight one-bit pulse-density microphone streams that share one bit clock. It turns them into per-channel sample strobes in a fast system clock domain. The bit clock arrives from outside and is brought into the system domain by a flop chain. Every change of its level, rising or falling, opens a new half period. A counter in the system domain restarts at each such change and then counts system cycles. Each channel has a programmable sample pointer. When the count reaches that pointer, the channel's data line is latched and a one-cycle valid strobe goes to the decimation chain.

Software normally sets each pointer to about three quarters of the half-period length. That length, measured in system cycles, is the system clock rate divided by twice the bit clock rate, rounded up. This places the capture instant after the microphone's output has settled. The design has three enables: a global enable, a per-channel active-low reset and a per-channel enable. If the bit clock stops, the counter stops at its largest value rather than wrapping. This means a stalled clock cannot produce a stream of false samples.

Top module: `pdm_chan_sampler`

## Requirements
- R1: After reset, `smp_vld` and `smp_bit` are all zero, and they stay zero until a capture takes place.
- R2: The pointer of channel i is taken from `ptr_cfg[8i+7:8i]`. Channels 0 to 3 lie in the lower 32-bit word and channels 4 to 7 in the upper word.
- R3: Any level change of `bclk_in`, rising or falling, restarts the half-period count at zero. A live channel produces exactly one strobe per half period, and that strobe is one cycle wide.
- R4: With pointer p and the default two-stage synchronizer, the strobe is high in the cycle after the (p+4)-th rising edge of `clk` that follows the `bclk_in` change.
- R5: `smp_bit[i]` equals `pdm_in[i]` as sampled at the rising edge that raises the strobe. It holds that value until the next strobe of that channel.
- R6: A channel whose `chan_rstn` bit is 0 gives no strobe. Its `smp_bit` reads 0 from the next cycle on.
- R7: A channel whose `chan_en` bit is 0 gives no strobe. Its `smp_bit` reads 0 from the next cycle on.
- R8: While `glb_en` is 0, there are no strobes and every `smp_bit` is 0. Once `glb_en` is 1 again, no strobe comes before the next `bclk_in` change.
- R9: If no bit-clock change occurs, the count stops at 255 and does not wrap. Each channel then strobes at most once after the last change, and a pointer of 255 strobes exactly once, 259 cycles after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | Shared microphone bit clock, asynchronous to clk |
| pdm_in | input | 8 | One data bit per microphone channel |
| glb_en | input | 1 | Global capture enable |
| chan_rstn | input | 8 | Per-channel active-low reset |
| chan_en | input | 8 | Per-channel enable |
| ptr_cfg | input | 64 | Packed 8-bit sample pointers, channel i at bits [8i+7:8i] |
| smp_vld | output | 8 | One-cycle capture strobe per channel |
| smp_bit | output | 8 | Latched data bit per channel |

## Verification
The bench advances the system clock one cycle at a time and reads the outputs at the falling edge. It keeps a phase count of the cycles since it last changed `bclk_in`. Every strobe it sees must arrive at phase pointer+4. That figure counts two synchronizer flops, one cycle for the counter to restart, p counting cycles and the output register. The captured bit must equal the data the bench drove for that half period. Strobes are counted only after the bench has stopped the bit clock and waited out the longest pointer plus the pipeline delay, so the per-channel totals are exact. Enable, reset and global-enable effects are read one cycle after the control change, and the stalled-clock case is watched for 400 cycles so that any wrap would show up.

// File: rtl/pdm_smp_pkg.sv
package pdm_smp_pkg;

   // Operating state of one capture lane
   typedef enum logic [1:0] {
      LANE_HELD = 2'd0,   // lane in reset
      LANE_OFF  = 2'd1,   // lane or block disabled
      LANE_LIVE = 2'd2    // lane capturing
   } lane_mode_e;

   function automatic lane_mode_e lane_mode(input logic glb, input logic rstn, input logic en);
      if (!rstn)            return LANE_HELD;
      else if (!(glb && en)) return LANE_OFF;
      else                  return LANE_LIVE;
   endfunction

endpackage

// File: rtl/pdm_bclk_sync.sv
module pdm_bclk_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_async,
   output logic edge_p
);
   localparam int unsigned LAST = STAGES;

   logic [LAST:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= bclk_async;
   end

   for (genvar k = 1; k <= LAST; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[k] <= 1'b0;
         else        chain[k] <= chain[k-1];
      end
   end

   // chain[LAST-1] is the last synchronizing flop, chain[LAST] its delayed copy
   assign edge_p = chain[LAST-1] ^ chain[LAST];

endmodule

// File: rtl/pdm_half_cnt.sv
module pdm_half_cnt #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         restart,
   output logic [W-1:0] cnt,
   output logic         fresh
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   // fresh marks a cycle in which cnt holds a newly reached value
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= TOP;
         fresh <= 1'b0;
      end else if (!run) begin
         cnt   <= TOP;
         fresh <= 1'b0;
      end else if (restart) begin
         cnt   <= '0;
         fresh <= 1'b1;
      end else if (cnt != TOP) begin
         cnt   <= cnt + 1'b1;
         fresh <= 1'b1;
      end else begin
         fresh <= 1'b0;
      end
   end

endmodule

// File: rtl/pdm_lane_cap.sv
module pdm_lane_cap
   import pdm_smp_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  lane_mode_e   mode,
   input  logic [W-1:0] ptr,
   input  logic [W-1:0] cnt,
   input  logic         fresh,
   input  logic         din,
   output logic         vld,
   output logic         dbit
);
   logic hit;
   assign hit = fresh && (cnt == ptr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         dbit <= 1'b0;
      end else if (mode != LANE_LIVE) begin
         vld  <= 1'b0;
         dbit <= 1'b0;
      end else begin
         vld <= hit;
         if (hit) dbit <= din;
      end
   end

endmodule

// File: rtl/pdm_chan_sampler.sv
module pdm_chan_sampler
   import pdm_smp_pkg::*;
#(
   parameter int unsigned NCH         = 8,
   parameter int unsigned PTR_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bclk_in,
   input  logic [NCH-1:0]       pdm_in,
   input  logic                 glb_en,
   input  logic [NCH-1:0]       chan_rstn,
   input  logic [NCH-1:0]       chan_en,
   input  logic [NCH*PTR_W-1:0] ptr_cfg,
   output logic [NCH-1:0]       smp_vld,
   output logic [NCH-1:0]       smp_bit
);
   localparam int unsigned CFG_W = NCH * PTR_W;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("pdm_chan_sampler: NCH must be 1..8");
   end
   if (PTR_W < 2) begin : g_bad_ptr
      $error("pdm_chan_sampler: PTR_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pdm_chan_sampler: SYNC_STAGES must be at least 2");
   end
   if (CFG_W != $bits(ptr_cfg)) begin : g_bad_cfg
      $error("pdm_chan_sampler: pointer bus width mismatch");
   end

   logic             bclk_edge;
   logic [PTR_W-1:0] hp_cnt;
   logic             hp_fresh;

   pdm_bclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .bclk_async (bclk_in),
      .edge_p     (bclk_edge)
   );

   pdm_half_cnt #(.W(PTR_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (glb_en),
      .restart (bclk_edge),
      .cnt     (hp_cnt),
      .fresh   (hp_fresh)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_lane
      lane_mode_e mode_i;
      assign mode_i = lane_mode(glb_en, chan_rstn[i], chan_en[i]);

      pdm_lane_cap #(.W(PTR_W)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .mode  (mode_i),
         .ptr   (ptr_cfg[i*PTR_W +: PTR_W]),
         .cnt   (hp_cnt),
         .fresh (hp_fresh),
         .din   (pdm_in[i]),
         .vld   (smp_vld[i]),
         .dbit  (smp_bit[i])
      );
   end

endmodule

// File: rtl/pdm_smp_chk.sv
module pdm_smp_chk #(
   parameter int unsigned NCH   = 8,
   parameter int unsigned PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             glb_en,
   input logic [NCH-1:0]   chan_rstn,
   input logic [NCH-1:0]   chan_en,
   input logic [NCH-1:0]   smp_vld,
   input logic [NCH-1:0]   smp_bit,
   input logic [PTR_W-1:0] cnt,
   input logic             edge_p
);
   localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};

   // R3
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_p && glb_en) |=> (cnt == '0));

   // R3
   one_cycle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((smp_vld & $past(smp_vld)) == '0));

   // R6
   lane_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((~$past(chan_rstn)) & (smp_vld | smp_bit)) == '0));

   // R7
   lane_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((~$past(chan_en)) & (smp_vld | smp_bit)) == '0));

   // R8
   global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> ((smp_vld | smp_bit) == '0));

   // R9
   saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TOP && !edge_p) |=> (cnt == TOP));

endmodule

bind pdm_chan_sampler pdm_smp_chk #(.NCH(NCH), .PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .glb_en    (glb_en),
   .chan_rstn (chan_rstn),
   .chan_en   (chan_en),
   .smp_vld   (smp_vld),
   .smp_bit   (smp_bit),
   .cnt       (hp_cnt),
   .edge_p    (bclk_edge)
);

// File: tb/sim_pdm_chan_sampler.sv
module sim_pdm_chan_sampler;
   localparam int CLK_PER = 10;
   localparam int NCH     = 8;
   localparam int HALF    = 24;   // bench half period in clk cycles

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bclk = 1'b0;
   logic [NCH-1:0]   pdm = '0;
   logic             glb_en = 1'b0;
   logic [NCH-1:0]   crst = '0;
   logic [NCH-1:0]   cen = '0;
   logic [NCH*8-1:0] ptr = '0;
   logic [NCH-1:0]   vld;
   logic [NCH-1:0]   sbit;

   int n_chk = 0, n_bad = 0;
   int phase = 0, tog_left = 0, hp_idx = 0, pat_sel = 0;
   bit done = 0;
   int s_cnt [NCH];
   int s_dly [NCH];
   int s_bit [NCH];

   always #(CLK_PER/2) clk = ~clk;

   pdm_chan_sampler u0 (
      .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .pdm_in(pdm), .glb_en(glb_en),
      .chan_rstn(crst), .chan_en(cen), .ptr_cfg(ptr), .smp_vld(vld), .smp_bit(sbit)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [NCH-1:0] pattern(input int k);
      if (pat_sel == 1) return '1;
      return 8'((k * 37 + 11) ^ (k << 3));
   endfunction

   // One clk cycle: sample at the falling edge, then move the bit clock
   task automatic step();
      @(negedge clk);
      phase++;
      for (int i = 0; i < NCH; i++) begin
         if (vld[i]) begin
            s_cnt[i]++;
            if (phase != int'(ptr[8*i +: 8]) + 4) s_dly[i]++;
            if (sbit[i] != pdm[i]) s_bit[i]++;
         end
      end
      if (tog_left > 0 && phase >= HALF) begin
         bclk = ~bclk;
         hp_idx++;
         pdm = pattern(hp_idx);
         phase = 0;
         tog_left--;
      end
   endtask

   task automatic steps(input int n);
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic clr_stats();
      for (int i = 0; i < NCH; i++) begin
         s_cnt[i] = 0; s_dly[i] = 0; s_bit[i] = 0;
      end
   endtask

   // n bit-clock changes, then a drain of one half period
   task automatic burst(input int n);
      tog_left = n;
      phase = HALF;
      while (tog_left > 0) step();
      steps(HALF);
   endtask

   task automatic set_ptrs(input int base, input int stride);
      for (int i = 0; i < NCH; i++) ptr[8*i +: 8] = 8'(base + stride * i);
   endtask

   task automatic expect_lanes(input string req, input logic [NCH-1:0] live, input int n);
      for (int i = 0; i < NCH; i++) begin
         check($sformatf("%s strobes ch%0d", req, i), s_cnt[i], live[i] ? n : 0);
         check($sformatf("R4 delay ch%0d", i), s_dly[i], 0);
         check($sformatf("R5 data ch%0d", i), s_bit[i], 0);
      end
   endtask

   task automatic t_reset();
      check("R1 vld after reset", int'(vld), 0);
      check("R1 bit after reset", int'(sbit), 0);
      steps(5);
      check("R1 vld idle", int'(vld), 0);
      check("R1 bit idle", int'(sbit), 0);
   endtask

   task automatic t_timing();
      glb_en = 1'b1; crst = '1; cen = '1; pat_sel = 0;
      set_ptrs(0, 2);          // R2: pointers 0,2,..,14, pointer 0 included
      steps(300); clr_stats();
      burst(6);
      expect_lanes("R3", '1, 6);
      set_ptrs(5, 2);          // R2: pointers 5..19
      steps(300); clr_stats();
      burst(5);
      expect_lanes("R3", '1, 5);
   endtask

   task automatic t_lane_ctl();
      pat_sel = 1;
      crst = 8'b1111_1100;     // ch0, ch1 held in reset (R6)
      cen  = 8'b1111_0111;     // ch3 disabled (R7)
      set_ptrs(4, 1);
      steps(300); clr_stats();
      burst(4);
      expect_lanes("R6/R7", 8'b1111_0100, 4);
      check("R5 live bit held", int'(sbit), 8'b1111_0100);
      cen[4] = 1'b0;
      steps(1);
      check("R7 bit cleared", int'(sbit[4]), 0);
      crst[5] = 1'b0;
      steps(1);
      check("R6 bit cleared", int'(sbit[5]), 0);
      check("R5 other bits kept", int'(sbit), 8'b1100_0100);
      crst = '1; cen = '1;
   endtask

   task automatic t_global();
      pat_sel = 1;
      set_ptrs(3, 1);
      ptr[8*7 +: 8] = 8'd255;
      glb_en = 1'b0;
      steps(2);
      check("R8 bits off", int'(sbit), 0);
      clr_stats();
      burst(3);
      for (int i = 0; i < NCH; i++) check($sformatf("R8 no strobe ch%0d", i), s_cnt[i], 0);
      glb_en = 1'b1;
      steps(300);
      for (int i = 0; i < NCH; i++) check($sformatf("R8 wait for edge ch%0d", i), s_cnt[i], 0);
      ptr[8*7 +: 8] = 8'd10;
      clr_stats();
      burst(2);
      expect_lanes("R8", '1, 2);
   endtask

   task automatic t_saturate();
      pat_sel = 0;
      set_ptrs(2, 3);
      ptr[7:0] = 8'd255;       // R9 pointer at the saturated count
      steps(300); clr_stats();
      tog_left = 1; phase = HALF;
      step();
      steps(400);
      for (int i = 0; i < NCH; i++) begin
         check($sformatf("R9 single strobe ch%0d", i), s_cnt[i], 1);
         check($sformatf("R9 delay ch%0d", i), s_dly[i], 0);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      clr_stats();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_timing();
      t_lane_ctl();
      t_global();
      t_saturate();
      finish_run();
   end

endmodule